// File: doc/BRIEF.md
# Reset and Brownout Sequencer

This block decides when the core may run. It watches three asynchronous inputs: the external active-low reset pin, the output of an analog supply-dip comparator, and the lock indication of the clock multiplier. From them it drives the internal core reset, a pad-disable signal that floats all general purpose ports, and a sticky flag that records that a supply dip has happened. The comparator, the input Schmitt trigger and the PLL itself sit outside the block.

Each input first passes through a two-flop synchronizer. A pin reset counts only once the pin has stayed low for a minimum number of machine cycles. A supply dip counts only once it has lasted a programmable number of clocks, and only while dip detection is enabled. As long as either cause is present, the core is held in reset. Once both causes are gone, the core is released only after the lock indication has stayed high for a fixed number of consecutive clocks. If lock drops during that wait, the count starts again from zero. The dip flag survives the dip-caused reset. It is cleared by a qualified pin reset or by a one-cycle software clear pulse. All pins are plain levels; there is no streaming interface.

Top module: `rst_bo_seq`

## Requirements
- R1: A reset pin low level reaches the timing logic through two synchronizer flops. It forces core reset (core_rst_n = 0) only when the low level is seen on at least PIN_MIN_MC*CLK_PER_MC consecutive rising clock edges. Exactly one edge fewer has no effect on core_rst_n.
- R2: After every reset cause has gone, core_rst_n stays 0 until the synchronized lock input has been 1 on LOCK_HOLD consecutive edges. With lock first driven high ahead of edge 0, core_rst_n is still 0 after edge LOCK_HOLD and reads 1 after edge LOCK_HOLD+1. A drop of lock during the wait restarts the count.
- R3: With bo_en = 1, a supply-dip input held high on at least BO_FILT consecutive edges forces core reset. One edge fewer has no effect.
- R4: port_tristate is 1 for exactly as long as a qualified supply dip (R3) is present, and 0 otherwise.
- R5: A qualified supply dip sets bo_flag to 1. The flag stays 1 after the dip ends and after the core has been released again.
- R6: bo_flag returns to 0 after a qualified pin reset (R1), or one clock after a one-cycle bo_clr pulse while no qualified dip is present. A pin reset clears the flag even when a dip is qualified in the same cycle.
- R7: While bo_en = 0, the supply-dip input has no effect: it causes no core reset, port_tristate stays 0, and bo_flag is not set.
- R8: While por_n is low, core_rst_n = 0, port_tristate = 0 and bo_flag = 0. Without lock, the core stays in reset after por_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset of the sequencer's own flops, active low |
| rst_pin_n | input | 1 | External reset pin after the input buffer, active low, asynchronous |
| bo_det | input | 1 | Supply-dip comparator output, active high, asynchronous |
| bo_en | input | 1 | Enables supply-dip detection |
| pll_lock | input | 1 | Clock multiplier lock indication, asynchronous |
| bo_clr | input | 1 | Software clear of bo_flag, one-cycle pulse, synchronous to clk |
| core_rst_n | output | 1 | Core reset, active low |
| port_tristate | output | 1 | Float all general purpose ports |
| bo_flag | output | 1 | Sticky supply-dip status |

## Verification
The bench builds the block with CLK_PER_MC = 3, PIN_MIN_MC = 2, BO_FILT = 8 and LOCK_HOLD = 64. This gives a 6-edge pin qualification and a 64-clock release wait. With these values, many random pin and dip pulses can straddle both qualification thresholds by a few edges on either side, and each one can be followed by a full release sequence within a short run. The exact release edge is checked after power-on and after a lock drop in the middle of the wait. The random pulses run with detection enabled and disabled, and the bench tracks a model of the sticky flag across them.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    RS_HOLD = 2'd0,
    RS_WAIT = 2'd1,
    RS_RUN  = 2'd2
  } rsq_state_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rsq_filter.sv
module rsq_filter #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic qual
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_len <= '0;
    else if (!act)                 run_len <= '0;
    else if (run_len != CW'(LEN))  run_len <= run_len + 1'b1;
  end

  assign qual = (run_len == CW'(LEN));

  // R1 / R3: any gap in the active level withdraws the qualification
  assert_gap_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !qual);

  // R3: qualification only follows an active sample
  assert_qual_after_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(act));
endmodule

// File: rtl/rsq_release.sv
module rsq_release
  import rsq_pkg::*;
#(
  parameter int LOCK_HOLD = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic lock,
  output logic run
);
  localparam int CW = (LOCK_HOLD > 1) ? $clog2(LOCK_HOLD) : 1;

  rsq_state_e    st;
  logic [CW-1:0] lock_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RS_HOLD;
      lock_cnt <= '0;
    end else if (hold) begin
      st       <= RS_HOLD;
      lock_cnt <= '0;
    end else begin
      unique case (st)
        RS_HOLD: begin
          st       <= RS_WAIT;
          lock_cnt <= '0;
        end
        RS_WAIT: begin
          if (!lock) begin
            lock_cnt <= '0;
          end else if (lock_cnt == CW'(LOCK_HOLD - 1)) begin
            st       <= RS_RUN;
            lock_cnt <= '0;
          end else begin
            lock_cnt <= lock_cnt + 1'b1;
          end
        end
        default: st <= RS_RUN;
      endcase
    end
  end

  assign run = (st == RS_RUN);

  // R3: a present reset cause puts the core into reset on the next edge
  assert_hold_forces_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !run);

  // R2: release happens only on an edge that saw lock
  assert_release_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(lock));

  // R2: losing lock during the wait keeps the core in reset
  assert_lock_loss_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_WAIT && !lock && !hold) |=> !run);
endmodule

// File: rtl/rst_bo_seq.sv
module rst_bo_seq #(
  parameter int CLK_PER_MC  = 6,
  parameter int PIN_MIN_MC  = 2,
  parameter int BO_FILT     = 16,
  parameter int LOCK_HOLD   = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic bo_det,
  input  logic bo_en,
  input  logic pll_lock,
  input  logic bo_clr,
  output logic core_rst_n,
  output logic port_tristate,
  output logic bo_flag
);
  localparam int PIN_LEN = CLK_PER_MC * PIN_MIN_MC;

  logic [2:0] raw_in, syn_in;
  logic       pin_s, bo_s, lock_s;
  logic       pin_qual, bo_qual, run;

  assign raw_in = {pll_lock, bo_det, rst_pin_n};

  rsq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(por_n), .d(raw_in), .q(syn_in)
  );

  assign pin_s  = syn_in[0];
  assign bo_s   = syn_in[1];
  assign lock_s = syn_in[2];

  rsq_filter #(.LEN(PIN_LEN)) u_pin_filt (
    .clk(clk), .rst_n(por_n), .act(!pin_s), .qual(pin_qual)
  );

  rsq_filter #(.LEN(BO_FILT)) u_bo_filt (
    .clk(clk), .rst_n(por_n), .act(bo_s && bo_en), .qual(bo_qual)
  );

  rsq_release #(.LOCK_HOLD(LOCK_HOLD)) u_rel (
    .clk(clk), .rst_n(por_n), .hold(pin_qual || bo_qual), .lock(lock_s), .run(run)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        bo_flag <= 1'b0;
    else if (pin_qual) bo_flag <= 1'b0;
    else if (bo_qual)  bo_flag <= 1'b1;
    else if (bo_clr)   bo_flag <= 1'b0;
  end

  assign core_rst_n    = run;
  assign port_tristate = bo_qual;

  // R5: a qualified dip sets the sticky flag
  assert_dip_sets_flag_R5: assert property (@(posedge clk) disable iff (!por_n)
    (bo_qual && !pin_qual) |=> bo_flag);

  // R6: a qualified pin reset clears the flag
  assert_pin_clears_flag_R6: assert property (@(posedge clk) disable iff (!por_n)
    pin_qual |=> !bo_flag);

  // R6: a software clear without a dip clears the flag
  assert_sw_clears_flag_R6: assert property (@(posedge clk) disable iff (!por_n)
    (bo_clr && !bo_qual && !pin_qual) |=> !bo_flag);

  // R7: the flag only rises while detection is enabled
  assert_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(bo_flag) |-> $past(bo_en));
endmodule

// File: tb/rst_bo_seq_tb_top.sv
module rst_bo_seq_tb_top;
  localparam int CPM  = 3;
  localparam int PMC  = 2;
  localparam int PINL = CPM * PMC;
  localparam int BOL  = 8;
  localparam int HOLD = 64;

  logic clk = 1'b0;
  logic por_n, rst_pin_n, bo_det, bo_en, pll_lock, bo_clr;
  logic core_rst_n, port_tristate, bo_flag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  saw_rst, saw_tri;
  bit  exp_flag;

  always #10 clk = ~clk;

  rst_bo_seq #(.CLK_PER_MC(CPM), .PIN_MIN_MC(PMC), .BO_FILT(BOL), .LOCK_HOLD(HOLD)) dut_i (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .bo_det(bo_det), .bo_en(bo_en),
    .pll_lock(pll_lock), .bo_clr(bo_clr), .core_rst_n(core_rst_n),
    .port_tristate(port_tristate), .bo_flag(bo_flag)
  );

  always @(negedge clk) begin
    if (!core_rst_n)   saw_rst = 1'b1;
    if (port_tristate) saw_tri = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic bit exp_reset(bit is_bo, int len, bit en);
    if (is_bo) return en && (len >= BOL);
    return len >= PINL;
  endfunction

  function automatic bit exp_tri(bit is_bo, int len, bit en);
    return is_bo && en && (len >= BOL);
  endfunction

  task automatic clear_seen();
    @(posedge clk);
    saw_rst = 1'b0;
    saw_tri = 1'b0;
  endtask

  task automatic pulse(input bit is_bo, input int len);
    @(negedge clk);
    if (is_bo) bo_det = 1'b1; else rst_pin_n = 1'b0;
    repeat (len) @(posedge clk);
    @(negedge clk);
    if (is_bo) bo_det = 1'b0; else rst_pin_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_release(input string req);
    repeat (HOLD + 20) @(posedge clk);
    @(negedge clk);
    chk(core_rst_n == 1'b1, req, core_rst_n, 1);
  endtask

  // exact release edge, lock driven high at the next negedge
  task automatic lock_rise_check(input string req);
    @(negedge clk);
    pll_lock = 1'b1;
    repeat (HOLD + 1) @(posedge clk);
    @(negedge clk);
    chk(core_rst_n == 1'b0, req, core_rst_n, 0);
    @(posedge clk);
    @(negedge clk);
    chk(core_rst_n == 1'b1, req, core_rst_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    por_n = 1'b0; rst_pin_n = 1'b1; bo_det = 1'b0; bo_en = 1'b1;
    pll_lock = 1'b0; bo_clr = 1'b0; exp_flag = 1'b0;
    repeat (3) @(negedge clk);
    // R8: power-on state
    chk(core_rst_n == 1'b0, "R8 core_rst_n", core_rst_n, 0);
    chk(port_tristate == 1'b0, "R8 port_tristate", port_tristate, 0);
    chk(bo_flag == 1'b0, "R8 bo_flag", bo_flag, 0);
    por_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(core_rst_n == 1'b0, "R8 no lock keeps reset", core_rst_n, 0);

    // R2: exact release edge after power-on
    lock_rise_check("R2 first release");

    // R2: lock drop during the wait restarts the count
    pulse(1'b0, PINL + 2);
    repeat (15) @(negedge clk);
    chk(core_rst_n == 1'b0, "R2 still waiting", core_rst_n, 0);
    pll_lock = 1'b0;
    repeat (3) @(negedge clk);
    lock_rise_check("R2 restart after lock loss");

    // R1: pin boundary
    clear_seen();
    pulse(1'b0, PINL - 1);
    chk(saw_rst == 1'b0, "R1 short pin ignored", saw_rst, 0);
    clear_seen();
    pulse(1'b0, PINL);
    chk(saw_rst == 1'b1, "R1 pin at threshold resets", saw_rst, 1);
    wait_release("R1 release after pin");

    // R3/R4/R5: dip boundary
    clear_seen();
    pulse(1'b1, BOL - 1);
    chk(saw_rst == 1'b0, "R3 short dip ignored", saw_rst, 0);
    chk(saw_tri == 1'b0, "R4 short dip no tristate", saw_tri, 0);
    chk(bo_flag == 1'b0, "R5 short dip no flag", bo_flag, 0);
    clear_seen();
    pulse(1'b1, BOL);
    chk(saw_rst == 1'b1, "R3 dip at threshold resets", saw_rst, 1);
    chk(saw_tri == 1'b1, "R4 tristate during dip", saw_tri, 1);
    chk(port_tristate == 1'b0, "R4 tristate ends with dip", port_tristate, 0);
    wait_release("R3 release after dip");
    chk(bo_flag == 1'b1, "R5 flag sticky after release", bo_flag, 1);

    // R6: software clear, then pin clear
    @(negedge clk); bo_clr = 1'b1;
    @(negedge clk); bo_clr = 1'b0;
    chk(bo_flag == 1'b0, "R6 software clear", bo_flag, 0);
    pulse(1'b1, BOL + 3);
    wait_release("R6 release");
    chk(bo_flag == 1'b1, "R6 flag set again", bo_flag, 1);
    pulse(1'b0, PINL + 1);
    chk(bo_flag == 1'b0, "R6 pin clears flag", bo_flag, 0);
    wait_release("R6 release after pin");

    // R7: detection disabled
    bo_en = 1'b0;
    clear_seen();
    pulse(1'b1, BOL + 10);
    chk(saw_rst == 1'b0, "R7 no reset when disabled", saw_rst, 0);
    chk(saw_tri == 1'b0, "R7 no tristate when disabled", saw_tri, 0);
    chk(bo_flag == 1'b0, "R7 no flag when disabled", bo_flag, 0);
    bo_en = 1'b1;

    // random pulses around both thresholds (R1 R3 R4 R5 R6 R7)
    exp_flag = 1'b0;
    for (int it = 0; it < 30; it++) begin
      bit is_bo, en, er, et;
      int len;
      is_bo = 1'($urandom % 2);
      en    = 1'($urandom % 2);
      len   = (is_bo ? BOL : PINL) - 3 + int'($urandom % 7);
      if (($urandom % 4) == 0) begin
        @(negedge clk); bo_clr = 1'b1;
        @(negedge clk); bo_clr = 1'b0;
        exp_flag = 1'b0;
      end
      @(negedge clk); bo_en = en;
      er = exp_reset(is_bo, len, en);
      et = exp_tri(is_bo, len, en);
      if (et) exp_flag = 1'b1;
      if (!is_bo && er) exp_flag = 1'b0;
      clear_seen();
      pulse(is_bo, len);
      chk(saw_rst == er, is_bo ? "R3 random dip reset" : "R1 random pin reset", saw_rst, er);
      chk(saw_tri == et, "R4 random tristate", saw_tri, et);
      chk(bo_flag == exp_flag, "R5 random flag", bo_flag, exp_flag);
      if (er) wait_release("R2 random release");
    end
    finish_run();
  end
endmodule